// File: doc/BRIEF.md
# Class-Steered Register Rename Table

This block maps architectural register indices onto physical register indices for an out-of-order core. The architectural index space is flat and covers three register classes in a fixed order: integer, then floating-point, then a miscellaneous class. A decoder splits each incoming index into its class and a position within that class. The integer and floating-point classes each have their own mapping table and their own pool of free physical registers. The miscellaneous class has no table. Each of its registers sits at a fixed physical slot placed after all renamable physical registers.

Three request ports can act in the same cycle. The rename port takes a fresh physical register for a destination and reports the new mapping together with the one it replaced. The lookup port reads the current mapping of a source operand. The set port overwrites a mapping, for use by commit and squash recovery. Every response appears on registered outputs one clock after the request. The free pools only hand registers out. They are pop-only counters that begin just past the physical registers that the reset mappings occupy.

Top module: `reg_rename_table`

## Requirements
- R1: Indices 0..NUM_INT_ARCH-1 are integer, the next NUM_FP_ARCH are floating-point, and the next NUM_MISC are miscellaneous. Any higher index raises the error output of the port that used it (ren_err, lkp_err, set_err), drives that port's mapping outputs to 0 and changes no state.
- R2: After reset, integer entry i maps to physical i and floating-point entry j maps to physical NUM_INT_PHYS+j. The integer pool hands out NUM_INT_ARCH..NUM_INT_PHYS-1 in ascending order. The floating-point pool hands out NUM_INT_PHYS+NUM_FP_ARCH..NUM_INT_PHYS+NUM_FP_PHYS-1 in ascending order.
- R3: A rename of an integer or floating-point register returns ren_new, the next register of that class's pool, and ren_prev, the mapping that held before. It then stores ren_new in the table. All port responses are registered, one cycle after the request.
- R4: A rename of a class zero register (integer index INT_ZERO, floating-point relative index FP_ZERO) returns ren_new = ren_prev = its reset physical index, takes nothing from the pool and leaves the table unchanged.
- R5: Miscellaneous register k maps to NUM_INT_PHYS+NUM_FP_PHYS+k. A lookup returns that value. A rename returns it as both ren_new and ren_prev and never stalls.
- R6: A set on a miscellaneous register changes nothing. set_err is raised when the supplied physical index differs from the fixed slot, and stays low when it matches.
- R7: Renames of one class take registers only from that class's pool. Once the integer pool is exhausted, a floating-point rename still succeeds, and the reverse also holds.
- R8: A rename of a non-zero integer or floating-point register whose pool is empty raises ren_stall, drives the mapping outputs to 0 and leaves the table and pool unchanged.
- R9: A set and a rename of the same integer or floating-point index in the same cycle: the set is written, and the rename is refused with ren_stall and takes nothing from the pool.
- R10: A lookup returns the table contents as they were before any write in the same cycle. A set on an integer or floating-point register writes the table and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | AW | Architectural destination index |
| lkp_valid | input | 1 | Lookup request |
| lkp_arch | input | AW | Architectural source index |
| set_valid | input | 1 | Set-entry request |
| set_arch | input | AW | Architectural index to overwrite |
| set_phys | input | PW | Physical index to store |
| ren_done | output | 1 | Rename response valid |
| ren_stall | output | 1 | Rename refused (pool empty or collision) |
| ren_err | output | 1 | Rename index illegal |
| ren_new | output | PW | New physical mapping |
| ren_prev | output | PW | Replaced physical mapping |
| lkp_done | output | 1 | Lookup response valid |
| lkp_err | output | 1 | Lookup index illegal |
| lkp_phys | output | PW | Current physical mapping |
| set_err | output | 1 | Set index illegal or miscellaneous mismatch |

## Verification
A set-entry (squash recovery) and a rename can both reach the table in the same cycle. Directed cycles drive both ports at one integer index and at one floating-point index. They expect the rename to be refused with the pool untouched and a later lookup to show the set value. The random phase draws the set index to match the rename index about a fifth of the time, mixed with unrelated pairs and lookups. A bench model judges each cycle by reading the old table for lookups and renames before it applies the writes.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    RC_INT  = 2'd0,
    RC_FP   = 2'd1,
    RC_MISC = 2'd2,
    RC_BAD  = 2'd3
  } reg_class_e;
endpackage

// File: rtl/rr_class_decode.sv
module rr_class_decode
  import rr_pkg::*;
#(
  parameter int N_INT  = 8,
  parameter int N_FP   = 8,
  parameter int N_MISC = 4,
  parameter int AW     = 5
) (
  input  logic [AW-1:0] arch,
  output reg_class_e    cls,
  output logic [AW-1:0] rel
);
  localparam int FP_START   = N_INT;
  localparam int MISC_START = N_INT + N_FP;
  localparam int END_IDX    = N_INT + N_FP + N_MISC;

  always_comb begin
    if (arch < AW'(FP_START)) begin
      cls = RC_INT;
      rel = arch;
    end else if (arch < AW'(MISC_START)) begin
      cls = RC_FP;
      rel = arch - AW'(FP_START);
    end else if (arch < AW'(END_IDX)) begin
      cls = RC_MISC;
      rel = arch - AW'(MISC_START);
    end else begin
      cls = RC_BAD;
      rel = '0;
    end
  end
endmodule

// File: rtl/rr_map_table.sv
module rr_map_table #(
  parameter int ENTRIES = 8,
  parameter int PW      = 6,
  parameter int BASE    = 0,
  localparam int LW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] rd_a_idx,
  output logic [PW-1:0] rd_a_data,
  input  logic [LW-1:0] rd_b_idx,
  output logic [PW-1:0] rd_b_data,
  input  logic          wa_en,
  input  logic [LW-1:0] wa_idx,
  input  logic [PW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [LW-1:0] wb_idx,
  input  logic [PW-1:0] wb_data
);
  logic [PW-1:0] map_q [ENTRIES];

  assign rd_a_data = map_q[rd_a_idx];
  assign rd_b_data = map_q[rd_b_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) map_q[i] <= PW'(BASE + i);
    end else begin
      if (wb_en) map_q[wb_idx] <= wb_data;
      if (wa_en) map_q[wa_idx] <= wa_data;
    end
  end
endmodule

// File: rtl/rr_free_list.sv
module rr_free_list #(
  parameter int FIRST = 8,
  parameter int COUNT = 8,
  parameter int PW    = 6,
  localparam int CW   = $clog2(COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  output logic          empty,
  output logic [PW-1:0] head,
  output logic [CW-1:0] avail
);
  logic [CW-1:0] taken_q;

  assign avail = CW'(COUNT) - taken_q;
  assign empty = (taken_q == CW'(COUNT));
  assign head  = PW'(FIRST) + PW'(taken_q);

  always_ff @(posedge clk) begin
    if (rst) taken_q <= '0;
    else if (pop && !empty) taken_q <= taken_q + CW'(1);
  end
endmodule

// File: rtl/reg_rename_table.sv
module reg_rename_table
  import rr_pkg::*;
#(
  parameter int NUM_INT_ARCH = 8,
  parameter int NUM_FP_ARCH  = 8,
  parameter int NUM_MISC     = 4,
  parameter int NUM_INT_PHYS = 16,
  parameter int NUM_FP_PHYS  = 16,
  parameter int INT_ZERO     = 0,
  parameter int FP_ZERO      = 0,
  parameter bit FP_HAS_ZERO  = 1'b1,
  localparam int AW = $clog2(NUM_INT_ARCH + NUM_FP_ARCH + NUM_MISC + 1),
  localparam int PW = $clog2(NUM_INT_PHYS + NUM_FP_PHYS + NUM_MISC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_arch,
  input  logic          lkp_valid,
  input  logic [AW-1:0] lkp_arch,
  input  logic          set_valid,
  input  logic [AW-1:0] set_arch,
  input  logic [PW-1:0] set_phys,
  output logic          ren_done,
  output logic          ren_stall,
  output logic          ren_err,
  output logic [PW-1:0] ren_new,
  output logic [PW-1:0] ren_prev,
  output logic          lkp_done,
  output logic          lkp_err,
  output logic [PW-1:0] lkp_phys,
  output logic          set_err
);
  localparam int FP_BASE   = NUM_INT_PHYS;
  localparam int MISC_BASE = NUM_INT_PHYS + NUM_FP_PHYS;
  localparam int INT_FREE  = NUM_INT_PHYS - NUM_INT_ARCH;
  localparam int FP_FREE   = NUM_FP_PHYS - NUM_FP_ARCH;
  localparam int IW        = $clog2(NUM_INT_ARCH);
  localparam int FW        = $clog2(NUM_FP_ARCH);
  localparam int ICW       = $clog2(INT_FREE + 1);
  localparam int FCW       = $clog2(FP_FREE + 1);

  reg_class_e    ren_cls, lkp_cls, set_cls;
  logic [AW-1:0] ren_rel, lkp_rel, set_rel;

  rr_class_decode #(.N_INT(NUM_INT_ARCH), .N_FP(NUM_FP_ARCH), .N_MISC(NUM_MISC), .AW(AW))
    u_dec_ren (.arch(ren_arch), .cls(ren_cls), .rel(ren_rel));
  rr_class_decode #(.N_INT(NUM_INT_ARCH), .N_FP(NUM_FP_ARCH), .N_MISC(NUM_MISC), .AW(AW))
    u_dec_lkp (.arch(lkp_arch), .cls(lkp_cls), .rel(lkp_rel));
  rr_class_decode #(.N_INT(NUM_INT_ARCH), .N_FP(NUM_FP_ARCH), .N_MISC(NUM_MISC), .AW(AW))
    u_dec_set (.arch(set_arch), .cls(set_cls), .rel(set_rel));

  logic          int_pop, fp_pop, int_empty, fp_empty;
  logic [PW-1:0] int_head, fp_head;
  logic [ICW-1:0] int_avail;
  logic [FCW-1:0] fp_avail;

  rr_free_list #(.FIRST(NUM_INT_ARCH), .COUNT(INT_FREE), .PW(PW)) u_int_pool (
    .clk(clk), .rst(rst), .pop(int_pop), .empty(int_empty), .head(int_head), .avail(int_avail));
  rr_free_list #(.FIRST(FP_BASE + NUM_FP_ARCH), .COUNT(FP_FREE), .PW(PW)) u_fp_pool (
    .clk(clk), .rst(rst), .pop(fp_pop), .empty(fp_empty), .head(fp_head), .avail(fp_avail));

  logic [PW-1:0] int_rd_ren, int_rd_lkp, fp_rd_ren, fp_rd_lkp;
  logic          int_set_en, fp_set_en;

  assign int_set_en = set_valid && (set_cls == RC_INT);
  assign fp_set_en  = set_valid && (set_cls == RC_FP);

  rr_map_table #(.ENTRIES(NUM_INT_ARCH), .PW(PW), .BASE(0)) u_int_map (
    .clk(clk), .rst(rst),
    .rd_a_idx(ren_rel[IW-1:0]), .rd_a_data(int_rd_ren),
    .rd_b_idx(lkp_rel[IW-1:0]), .rd_b_data(int_rd_lkp),
    .wa_en(int_set_en), .wa_idx(set_rel[IW-1:0]), .wa_data(set_phys),
    .wb_en(int_pop), .wb_idx(ren_rel[IW-1:0]), .wb_data(int_head));
  rr_map_table #(.ENTRIES(NUM_FP_ARCH), .PW(PW), .BASE(FP_BASE)) u_fp_map (
    .clk(clk), .rst(rst),
    .rd_a_idx(ren_rel[FW-1:0]), .rd_a_data(fp_rd_ren),
    .rd_b_idx(lkp_rel[FW-1:0]), .rd_b_data(fp_rd_lkp),
    .wa_en(fp_set_en), .wa_idx(set_rel[FW-1:0]), .wa_data(set_phys),
    .wb_en(fp_pop), .wb_idx(ren_rel[FW-1:0]), .wb_data(fp_head));

  // zero-register detection; the floating-point class may be built without one
  logic int_zero_hit, fp_zero_hit;
  assign int_zero_hit = (ren_rel == AW'(INT_ZERO));
  generate
    if (FP_HAS_ZERO) begin : g_fp_zero
      assign fp_zero_hit = (ren_rel == AW'(FP_ZERO));
    end else begin : g_fp_nozero
      assign fp_zero_hit = 1'b0;
    end
  endgenerate

  logic          collide;
  logic          n_stall, n_rerr, n_lerr, n_serr;
  logic [PW-1:0] n_new, n_prev, n_lphys;

  assign collide = ren_valid && set_valid && (ren_arch == set_arch) &&
                   (ren_cls == RC_INT || ren_cls == RC_FP);

  always_comb begin
    int_pop = 1'b0;
    fp_pop  = 1'b0;
    n_stall = 1'b0;
    n_rerr  = 1'b0;
    n_new   = '0;
    n_prev  = '0;
    if (ren_valid) begin
      unique case (ren_cls)
        RC_INT: begin
          if (collide) n_stall = 1'b1;
          else if (int_zero_hit) begin
            n_new  = PW'(INT_ZERO);
            n_prev = PW'(INT_ZERO);
          end else if (int_empty) n_stall = 1'b1;
          else begin
            int_pop = 1'b1;
            n_new   = int_head;
            n_prev  = int_rd_ren;
          end
        end
        RC_FP: begin
          if (collide) n_stall = 1'b1;
          else if (fp_zero_hit) begin
            n_new  = PW'(FP_BASE + FP_ZERO);
            n_prev = PW'(FP_BASE + FP_ZERO);
          end else if (fp_empty) n_stall = 1'b1;
          else begin
            fp_pop = 1'b1;
            n_new  = fp_head;
            n_prev = fp_rd_ren;
          end
        end
        RC_MISC: begin
          n_new  = PW'(MISC_BASE) + PW'(ren_rel);
          n_prev = PW'(MISC_BASE) + PW'(ren_rel);
        end
        default: n_rerr = 1'b1;
      endcase
    end
  end

  always_comb begin
    n_lerr  = 1'b0;
    n_lphys = '0;
    unique case (lkp_cls)
      RC_INT:  n_lphys = int_rd_lkp;
      RC_FP:   n_lphys = fp_rd_lkp;
      RC_MISC: n_lphys = PW'(MISC_BASE) + PW'(lkp_rel);
      default: n_lerr  = 1'b1;
    endcase
  end

  always_comb begin
    n_serr = 1'b0;
    if (set_valid) begin
      if (set_cls == RC_BAD) n_serr = 1'b1;
      else if (set_cls == RC_MISC) n_serr = (set_phys != PW'(MISC_BASE) + PW'(set_rel));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ren_done  <= 1'b0;
      ren_stall <= 1'b0;
      ren_err   <= 1'b0;
      ren_new   <= '0;
      ren_prev  <= '0;
      lkp_done  <= 1'b0;
      lkp_err   <= 1'b0;
      lkp_phys  <= '0;
      set_err   <= 1'b0;
    end else begin
      ren_done  <= ren_valid;
      ren_stall <= n_stall;
      ren_err   <= n_rerr;
      ren_new   <= n_new;
      ren_prev  <= n_prev;
      lkp_done  <= lkp_valid;
      lkp_err   <= lkp_valid && n_lerr;
      lkp_phys  <= lkp_valid ? n_lphys : '0;
      set_err   <= n_serr;
    end
  end
endmodule

// File: rtl/rr_rename_checker.sv
module rr_rename_checker #(
  parameter int PW        = 6,
  parameter int ICW       = 4,
  parameter int FCW       = 4,
  parameter int MISC_BASE = 32,
  parameter int PHYS_ALL  = 36
) (
  input logic           clk,
  input logic           rst,
  input logic           ren_done,
  input logic           ren_stall,
  input logic           ren_err,
  input logic [PW-1:0]  ren_new,
  input logic [PW-1:0]  ren_prev,
  input logic           lkp_done,
  input logic           lkp_err,
  input logic [PW-1:0]  lkp_phys,
  input logic [ICW-1:0] int_avail,
  input logic [FCW-1:0] fp_avail
);
  assert_bad_index_R1: assert property (@(posedge clk) disable iff (rst)
    ren_err |-> (ren_new == '0 && ren_prev == '0 && !ren_stall));

  assert_stall_is_response_R8: assert property (@(posedge clk) disable iff (rst)
    ren_stall |-> (ren_done && ren_new == '0 && ren_prev == '0));

  assert_misc_fixed_R5: assert property (@(posedge clk) disable iff (rst)
    (ren_done && !ren_err && !ren_stall && ren_new >= PW'(MISC_BASE)) |-> ren_new == ren_prev);

  assert_int_pool_step_R7: assert property (@(posedge clk) disable iff (rst)
    ##1 (int_avail <= $past(int_avail)) && ($past(int_avail) - int_avail <= ICW'(1)));

  assert_fp_pool_step_R7: assert property (@(posedge clk) disable iff (rst)
    ##1 (fp_avail <= $past(fp_avail)) && ($past(fp_avail) - fp_avail <= FCW'(1)));

  assert_lookup_range_R10: assert property (@(posedge clk) disable iff (rst)
    (lkp_done && !lkp_err) |-> lkp_phys < PW'(PHYS_ALL));
endmodule

bind reg_rename_table rr_rename_checker #(
  .PW(PW), .ICW(ICW), .FCW(FCW), .MISC_BASE(MISC_BASE),
  .PHYS_ALL(NUM_INT_PHYS + NUM_FP_PHYS + NUM_MISC)
) u_rr_checker (
  .clk(clk), .rst(rst),
  .ren_done(ren_done), .ren_stall(ren_stall), .ren_err(ren_err),
  .ren_new(ren_new), .ren_prev(ren_prev),
  .lkp_done(lkp_done), .lkp_err(lkp_err), .lkp_phys(lkp_phys),
  .int_avail(int_avail), .fp_avail(fp_avail)
);

// File: tb/test_reg_rename_table.sv
`timescale 1ns/100ps
module test_reg_rename_table;
  localparam int NI = 8, NF = 8, NM = 4, NIP = 16, NFP = 16;
  localparam int AW = 5, PW = 6;
  localparam int MB = NIP + NFP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ren_valid = 0, lkp_valid = 0, set_valid = 0;
  logic [AW-1:0] ren_arch = '0, lkp_arch = '0, set_arch = '0;
  logic [PW-1:0] set_phys = '0;
  logic ren_done, ren_stall, ren_err, lkp_done, lkp_err, set_err;
  logic [PW-1:0] ren_new, ren_prev, lkp_phys;

  always #2.5 clk = ~clk;

  reg_rename_table i_reg_rename_table (
    .clk(clk), .rst(rst),
    .ren_valid(ren_valid), .ren_arch(ren_arch),
    .lkp_valid(lkp_valid), .lkp_arch(lkp_arch),
    .set_valid(set_valid), .set_arch(set_arch), .set_phys(set_phys),
    .ren_done(ren_done), .ren_stall(ren_stall), .ren_err(ren_err),
    .ren_new(ren_new), .ren_prev(ren_prev),
    .lkp_done(lkp_done), .lkp_err(lkp_err), .lkp_phys(lkp_phys),
    .set_err(set_err));

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model
  int imap [NI];
  int fmap [NF];
  int itaken, ftaken;

  // expected response of the current cycle
  int e_rstall, e_rerr, e_new, e_prev, e_lerr, e_lphys, e_serr;
  string r_tag, l_tag, s_tag;

  task automatic check(string tag, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int cls_of(int a);
    if (a < NI) return 0;
    if (a < NI + NF) return 1;
    if (a < NI + NF + NM) return 2;
    return 3;
  endfunction

  function automatic int rel_of(int a);
    case (cls_of(a))
      0: return a;
      1: return a - NI;
      2: return a - NI - NF;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NI; i++) imap[i] = i;
    for (int j = 0; j < NF; j++) fmap[j] = NIP + j;
    itaken = 0;
    ftaken = 0;
  endtask

  task automatic model_step(bit rv, int ra, bit lv, int la, bit sv, int sa, int sp);
    int rc, rr, lc, lr, sc, sr;
    bit collide;
    rc = cls_of(ra); rr = rel_of(ra);
    lc = cls_of(la); lr = rel_of(la);
    sc = cls_of(sa); sr = rel_of(sa);
    e_rstall = 0; e_rerr = 0; e_new = 0; e_prev = 0; r_tag = "R3";
    e_lerr = 0; e_lphys = 0; l_tag = "R10";
    e_serr = 0; s_tag = "R10";
    // lookup sees the old table
    if (lv) begin
      case (lc)
        0: e_lphys = imap[lr];
        1: e_lphys = fmap[lr];
        2: begin e_lphys = MB + lr; l_tag = "R5"; end
        default: begin e_lerr = 1; l_tag = "R1"; end
      endcase
    end
    collide = rv && sv && (ra == sa) && (rc < 2);
    if (rv) begin
      if (rc == 3) begin e_rerr = 1; r_tag = "R1"; end
      else if (rc == 2) begin e_new = MB + rr; e_prev = e_new; r_tag = "R5"; end
      else if (collide) begin e_rstall = 1; r_tag = "R9"; end
      else if (rc == 0 && rr == 0) begin e_new = 0; e_prev = 0; r_tag = "R4"; end
      else if (rc == 1 && rr == 0) begin e_new = NIP; e_prev = NIP; r_tag = "R4"; end
      else if (rc == 0) begin
        if (itaken == NIP - NI) begin e_rstall = 1; r_tag = "R8"; end
        else begin
          e_new = NI + itaken; e_prev = imap[rr];
          itaken++;
          imap[rr] = e_new;
        end
      end else begin
        if (ftaken == NFP - NF) begin e_rstall = 1; r_tag = "R8"; end
        else begin
          e_new = NIP + NF + ftaken; e_prev = fmap[rr];
          ftaken++;
          fmap[rr] = e_new;
        end
      end
    end
    if (sv) begin
      case (sc)
        0: imap[sr] = sp;
        1: fmap[sr] = sp;
        2: begin e_serr = (sp != MB + sr); s_tag = "R6"; end
        default: begin e_serr = 1; s_tag = "R1"; end
      endcase
    end
  endtask

  // one request cycle: drive at negedge, check after the next posedge
  task automatic cycle(bit rv, int ra, bit lv, int la, bit sv, int sa, int sp, string tag_over = "");
    @(negedge clk);
    ren_valid = rv; ren_arch = AW'(ra);
    lkp_valid = lv; lkp_arch = AW'(la);
    set_valid = sv; set_arch = AW'(sa); set_phys = PW'(sp);
    model_step(rv, ra, lv, la, sv, sa, sp);
    if (tag_over != "") begin r_tag = tag_over; l_tag = tag_over; end
    @(posedge clk);
    #1;
    check(r_tag, ren_done, rv, "ren_done");
    if (rv) begin
      check(r_tag, ren_stall, e_rstall, "ren_stall");
      check(r_tag, ren_err, e_rerr, "ren_err");
      check(r_tag, ren_new, e_new, "ren_new");
      check(r_tag, ren_prev, e_prev, "ren_prev");
    end
    check(l_tag, lkp_done, lv, "lkp_done");
    if (lv) begin
      check(l_tag, lkp_err, e_lerr, "lkp_err");
      check(l_tag, lkp_phys, e_lphys, "lkp_phys");
    end
    check(s_tag, set_err, sv ? e_serr : 0, "set_err");
    @(negedge clk);
    ren_valid = 0; lkp_valid = 0; set_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    model_reset();
  endtask

  task automatic random_phase(int n);
    for (int k = 0; k < n; k++) begin
      bit rv, lv, sv;
      int ra, la, sa, sp, sc;
      rv = ($urandom % 2) == 0;
      lv = ($urandom % 2) == 0;
      sv = ($urandom % 3) == 0;
      ra = $urandom % 22;
      la = $urandom % 24;
      sa = (($urandom % 5) == 0) ? ra : ($urandom % 24);
      sc = cls_of(sa);
      if (sc == 0) sp = $urandom % NIP;
      else if (sc == 1) sp = NIP + ($urandom % NFP);
      else if (sc == 2) sp = (($urandom % 2) == 0) ? MB + rel_of(sa) : ($urandom % 36);
      else sp = $urandom % 36;
      cycle(rv, ra, lv, la, sv, sa, sp);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset();
    // R2: outputs idle after reset
    #1;
    check("R2", ren_done, 0, "ren_done after reset");
    check("R2", lkp_done, 0, "lkp_done after reset");
    check("R2", set_err, 0, "set_err after reset");
    // R2: reset mappings of every renamable and misc register
    for (int a = 0; a < NI + NF + NM; a++) cycle(0, 0, 1, a, 0, 0, 0, a < NI + NF ? "R2" : "");
    // R2/R3: first renames take the lowest pool entries
    cycle(1, 3, 0, 0, 0, 0, 0, "R2");
    cycle(1, NI + 2, 1, 3, 0, 0, 0, "R2");
    // R4: zero registers
    cycle(1, 0, 1, 0, 0, 0, 0);
    cycle(1, NI, 1, NI, 0, 0, 0);
    // R5 and R6: misc rename, matching and mismatching set
    cycle(1, NI + NF + 2, 1, NI + NF + 3, 1, NI + NF + 1, MB + 1);
    cycle(0, 0, 1, NI + NF + 1, 1, NI + NF + 1, 5);
    // R1: illegal index on every port
    cycle(1, 25, 1, 30, 1, 21, 7);
    // R9: set and rename of one register in one cycle, then lookup
    cycle(1, 5, 0, 0, 1, 5, 14);
    cycle(0, 0, 1, 5, 0, 0, 0, "R9");
    cycle(1, NI + 4, 0, 0, 1, NI + 4, NIP + 3);
    cycle(1, NI + 4, 1, NI + 4, 0, 0, 0, "R9");
    // R10: lookup in the same cycle as a rename of that register sees the old value
    cycle(1, 6, 1, 6, 1, 2, 11);
    cycle(0, 0, 1, 2, 0, 0, 0);
    // R8: drain the integer pool, then R7: float pool still serves
    for (int k = 0; k < 8; k++) cycle(1, 1 + (k % 7), 0, 0, 0, 0, 0);
    cycle(1, NI + 1, 0, 0, 0, 0, 0, "R7");
    for (int k = 0; k < 8; k++) cycle(1, NI + 1 + (k % 7), 0, 0, 0, 0, 0);
    cycle(1, 0, 0, 0, 0, 0, 0);
    // random phases with a reset between them
    random_phase(400);
    do_reset();
    random_phase(400);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule